// File: doc/BRIEF.md
# Shift-Based Recursive Smoother with Threshold Monitor

This block post-processes the stream of results from one converter unit. Each accepted result goes through a first-order recursive smoothing filter, new output = ((k-1)/k) × previous output + sample / k. The weight k is chosen by a three-bit code from the set 2, 4, 8, 16 and 64. The filter keeps one state for all enabled channels of its unit, so results from different channels of that unit blend into a single running value.

A threshold monitor compares each filtered result with a programmed threshold. It looks either for results strictly above or strictly below that threshold. It sets a sticky monitor flag, and every accepted result also sets a sticky measurement-done flag. Both flags are cleared by writing ones, and they drive one interrupt line through a mask.

Results are dropped before the filter and the monitor when they carry the wrong unit tag or a channel index that the arbiter marks as invalid, meaning one at or above the channel count.

Top module: `sample_smoother_mon`

## Requirements
- R1: A result is accepted only when in_valid is high, in_unit equals UNIT_SEL and in_chan is below NUM_CH. Any other result leaves out_valid low, and the filter state and the status flags unchanged.
- R2: With filtering enabled, the state holds FRAC_W fractional bits and updates as state + floor((sample·2^FRAC_W − state) / 2^s). The shift s is 1, 2, 3, 4 and 6 for coefficient codes 0, 1, 2, 3 and 4. out_data is the integer part of the new state.
- R3: Coefficient codes 5, 6 and 7 behave as code 4 (k = 64).
- R4: The first accepted result after reset, or after filt_en has been low, loads the state directly, so out_data equals that sample.
- R5: While filt_en is low, out_data equals each accepted sample.
- R6: out_valid is high for exactly the cycle after the clock edge that accepts a result, with out_data valid in that cycle.
- R7: With mon_en high, status bit 0 (monitor) is set at the same edge as out_valid when the new result is strictly greater than mon_thresh (mon_dir = 0) or strictly less than it (mon_dir = 1). An equal result does not set it.
- R8: Status bit 1 (measurement done) is set at every edge that accepts a result.
- R9: A status bit stays set until a cycle with its irq_clr bit high. If a new event arrives in the same cycle as the clear, the bit stays set.
- R10: irq is high exactly when some irq_status bit and the same irq_mask bit are both high. Mask value 1 selects the monitor flag, 2 the done flag and 3 both.
- R11: While rst_n is low at a clock edge, out_valid, out_data and irq_status are cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Result strobe |
| in_unit | input | 1 | Unit tag of the result |
| in_chan | input | CH_W | Channel index of the result |
| in_data | input | DATA_W | Conversion result |
| filt_en | input | 1 | Filter enable |
| filt_code | input | 3 | Coefficient code |
| mon_en | input | 1 | Monitor enable |
| mon_dir | input | 1 | 0: above threshold, 1: below threshold |
| mon_thresh | input | DATA_W | Monitor threshold |
| irq_mask | input | 2 | Interrupt mask (bit 0 monitor, bit 1 done) |
| irq_clr | input | 2 | Write-one-to-clear for the status bits |
| out_valid | output | 1 | Filtered result strobe |
| out_data | output | DATA_W | Filtered result |
| irq_status | output | 2 | Sticky status (bit 0 monitor, bit 1 done) |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that inputs are stable around the rising edge. They also assume that the threshold, direction and enable bits seen in the accepting cycle are the ones that apply to that result. The bench drives every input only at the falling edge, and it changes configuration and results together in the same cycle, so both assumptions hold. The random stimulus deliberately includes wrong unit tags, channel indices from 10 to 15 and coefficient codes 5 to 7. These keep the drop path and the alias path within what the properties describe.

// File: rtl/ss_pkg.sv
// Shared constants and helpers for the smoother/monitor block.
// Assumes the coefficient code is three bits wide.
package ss_pkg;
    localparam int MON_BIT  = 0;
    localparam int DONE_BIT = 1;

    // Map a coefficient code to its right-shift amount; codes above 4 alias k=64.
    function automatic logic [2:0] coef_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 3'd1;
            3'd1:    return 3'd2;
            3'd2:    return 3'd3;
            3'd3:    return 3'd4;
            default: return 3'd6;
        endcase
    endfunction
endpackage

// File: rtl/ss_gate.sv
// Input qualifier: accepts a result only for the owning unit and a legal channel.
// Assumes channel indices at or above NUM_CH are marked invalid by the arbiter.
module ss_gate #(
    parameter int CH_W     = 4,
    parameter int NUM_CH   = 10,
    parameter bit UNIT_SEL = 1'b0
) (
    input  logic            in_valid,
    input  logic            in_unit,
    input  logic [CH_W-1:0] in_chan,
    output logic            acc
);
    localparam logic [CH_W-1:0] CH_LIM = CH_W'(NUM_CH);

    // Combine strobe, unit match and channel range.
    always_comb acc = in_valid && (in_unit == UNIT_SEL) && (in_chan < CH_LIM);
endmodule

// File: rtl/ss_iir.sv
// Recursive smoother with FRAC_W fractional state bits; shifts only, no multiply.
// Assumes filt_code is stable during the accepting cycle.
module ss_iir
    import ss_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              filt_en,
    input  logic [2:0]        filt_code,
    input  logic [DATA_W-1:0] sample,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [DATA_W-1:0] res_comb
);
    localparam int ST_W = DATA_W + FRAC_W;

    logic [ST_W-1:0]   state_q, state_d, sample_ext, blended;
    logic              primed_q;
    logic signed [ST_W:0] diff, step, sum;

    // Compute the next state: direct load or shifted blend.
    always_comb begin
        sample_ext = {sample, {FRAC_W{1'b0}}};
        diff       = $signed({1'b0, sample_ext}) - $signed({1'b0, state_q});
        step       = diff >>> coef_shift(filt_code);
        sum        = $signed({1'b0, state_q}) + step;
        blended    = sum[ST_W-1:0];
        state_d    = (!filt_en || !primed_q) ? sample_ext : blended;
        res_comb   = state_d[ST_W-1:FRAC_W];
    end

    // Register state, primed flag and the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= '0;
            primed_q  <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= acc;
            primed_q  <= filt_en && (primed_q || acc);
            if (acc) begin
                state_q  <= state_d;
                out_data <= res_comb;
            end
        end
    end
endmodule

// File: rtl/ss_monitor.sv
// Threshold comparator and sticky write-one-to-clear status with masked interrupt.
// Assumes the compared value is the result being registered at the same edge.
module ss_monitor
    import ss_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [DATA_W-1:0] result,
    input  logic              mon_en,
    input  logic              mon_dir,
    input  logic [DATA_W-1:0] mon_thresh,
    input  logic [1:0]        irq_mask,
    input  logic [1:0]        irq_clr,
    output logic [1:0]        irq_status,
    output logic              irq
);
    logic [1:0] set_ev;
    logic       hit;

    // Strict comparison in the selected direction.
    always_comb begin
        hit              = mon_dir ? (result < mon_thresh) : (result > mon_thresh);
        set_ev           = '0;
        set_ev[MON_BIT]  = acc && mon_en && hit;
        set_ev[DONE_BIT] = acc;
    end

    // Sticky status: clear by one, new event wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_status <= '0;
        else        irq_status <= (irq_status & ~irq_clr) | set_ev;
    end

    // Masked interrupt line.
    always_comb irq = |(irq_status & irq_mask);
endmodule

// File: rtl/sample_smoother_mon.sv
// Top: per-unit result smoother and threshold monitor.
// Assumes one filter state is shared by all enabled channels of the unit.
module sample_smoother_mon #(
    parameter int DATA_W   = 12,
    parameter int FRAC_W   = 6,
    parameter int CH_W     = 4,
    parameter int NUM_CH   = 10,
    parameter bit UNIT_SEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_unit,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DATA_W-1:0] in_data,
    input  logic              filt_en,
    input  logic [2:0]        filt_code,
    input  logic              mon_en,
    input  logic              mon_dir,
    input  logic [DATA_W-1:0] mon_thresh,
    input  logic [1:0]        irq_mask,
    input  logic [1:0]        irq_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        irq_status,
    output logic              irq
);
    logic              acc;
    logic [DATA_W-1:0] res_comb;

    ss_gate #(.CH_W(CH_W), .NUM_CH(NUM_CH), .UNIT_SEL(UNIT_SEL)) u_gate (
        .in_valid(in_valid), .in_unit(in_unit), .in_chan(in_chan), .acc(acc)
    );

    ss_iir #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_iir (
        .clk(clk), .rst_n(rst_n), .acc(acc), .filt_en(filt_en),
        .filt_code(filt_code), .sample(in_data),
        .out_valid(out_valid), .out_data(out_data), .res_comb(res_comb)
    );

    ss_monitor #(.DATA_W(DATA_W)) u_mon (
        .clk(clk), .rst_n(rst_n), .acc(acc), .result(res_comb),
        .mon_en(mon_en), .mon_dir(mon_dir), .mon_thresh(mon_thresh),
        .irq_mask(irq_mask), .irq_clr(irq_clr),
        .irq_status(irq_status), .irq(irq)
    );
endmodule

// File: rtl/ss_checker.sv
// Property checker for sample_smoother_mon, bound to every instance.
module ss_checker #(
    parameter int DATA_W   = 12,
    parameter int CH_W     = 4,
    parameter int NUM_CH   = 10,
    parameter bit UNIT_SEL = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_unit,
    input logic [CH_W-1:0]   in_chan,
    input logic [DATA_W-1:0] in_data,
    input logic              filt_en,
    input logic              mon_en,
    input logic              mon_dir,
    input logic [DATA_W-1:0] mon_thresh,
    input logic [1:0]        irq_clr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [1:0]        irq_status
);
    localparam logic [CH_W-1:0] CH_LIM = CH_W'(NUM_CH);
    logic ok_in;
    always_comb ok_in = in_valid && (in_unit == UNIT_SEL) && (in_chan < CH_LIM);

    // R1
    dropped_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_in |=> !out_valid);
    // R5
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_in && !filt_en) |=> (out_valid && out_data == $past(in_data)));
    // R7
    mon_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_in && !filt_en && mon_en && !mon_dir && in_data > mon_thresh) |=> irq_status[0]);
    // R8
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> irq_status[1]);
    // R9
    sticky_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[0] && !irq_clr[0]) |=> irq_status[0]);
    // R9
    sticky_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[1] && !irq_clr[1]) |=> irq_status[1]);
    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && irq_status == 2'b00 && out_data == '0));
endmodule

bind sample_smoother_mon ss_checker #(
    .DATA_W(DATA_W), .CH_W(CH_W), .NUM_CH(NUM_CH), .UNIT_SEL(UNIT_SEL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_chan(in_chan), .in_data(in_data), .filt_en(filt_en), .mon_en(mon_en),
    .mon_dir(mon_dir), .mon_thresh(mon_thresh), .irq_clr(irq_clr),
    .out_valid(out_valid), .out_data(out_data), .irq_status(irq_status)
);

// File: tb/tb_sample_smoother_mon.sv
module tb_sample_smoother_mon;
    localparam int DATA_W = 12;
    localparam int FRAC_W = 6;
    localparam int CH_W   = 4;
    localparam int NUM_CH = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_unit = 1'b0;
    logic [CH_W-1:0] in_chan = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic filt_en = 1'b0;
    logic [2:0] filt_code = '0;
    logic mon_en = 1'b0, mon_dir = 1'b0;
    logic [DATA_W-1:0] mon_thresh = '0;
    logic [1:0] irq_mask = '0, irq_clr = '0;
    logic out_valid;
    logic [DATA_W-1:0] out_data;
    logic [1:0] irq_status;
    logic irq;

    always #5 clk = ~clk;

    sample_smoother_mon dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
        .in_chan(in_chan), .in_data(in_data), .filt_en(filt_en),
        .filt_code(filt_code), .mon_en(mon_en), .mon_dir(mon_dir),
        .mon_thresh(mon_thresh), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .out_valid(out_valid), .out_data(out_data),
        .irq_status(irq_status), .irq(irq)
    );

    int n_chk = 0, n_err = 0;
    string phase = "reset";
    int m_state = 0;
    bit m_primed = 1'b0;
    int e_valid = 0, e_data = 0, e_status = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s [%s]: got %0d expected %0d", tag, phase, act, exp);
        end
    endtask

    function automatic int shift_of(input int code);
        case (code)
            0: return 1; 1: return 2; 2: return 3; 3: return 4;
            default: return 6; // R3 alias
        endcase
    endfunction

    // One cycle: predict from current inputs, clock, check at falling edge.
    task automatic step();
        bit ac;
        int s0;
        ac = in_valid && (in_unit == 1'b0) && (int'(in_chan) < NUM_CH);
        if (!filt_en) begin
            if (ac) m_state = int'(in_data) << FRAC_W;
            m_primed = 1'b0;
        end else if (ac) begin
            if (!m_primed) m_state = int'(in_data) << FRAC_W;
            else m_state = m_state + (((int'(in_data) << FRAC_W) - m_state) >>> shift_of(int'(filt_code)));
            m_primed = 1'b1;
        end
        e_valid = ac;
        if (ac) e_data = m_state >>> FRAC_W;
        s0 = ac && mon_en && (mon_dir ? (e_data < int'(mon_thresh)) : (e_data > int'(mon_thresh)));
        e_status = (e_status & ~int'(irq_clr)) | s0 | (int'(ac) << 1);
        @(posedge clk);
        @(negedge clk);
        chk("R6 out_valid", int'(out_valid), e_valid);
        if (e_valid) chk("R2 out_data", int'(out_data), e_data);
        chk("R9 irq_status", int'(irq_status), e_status);
        chk("R10 irq", int'(irq), int'((e_status & int'(irq_mask)) != 0));
        in_valid = 1'b0;
        irq_clr = '0;
    endtask

    task automatic put(input int unit, input int ch, input int d);
        in_valid = 1'b1; in_unit = unit[0]; in_chan = CH_W'(ch); in_data = DATA_W'(d);
    endtask

    initial begin
        #2000000;
        n_err++; n_chk++;
        $display("FAIL watchdog: got hung expected done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 out_valid", int'(out_valid), 0);
        chk("R11 status", int'(irq_status), 0);
        chk("R11 irq", int'(irq), 0);

        // R4 first sample loads directly, then R2 with k=64
        phase = "R4"; filt_en = 1; filt_code = 4; irq_mask = 2'b11;
        put(0, 3, 1000); step();
        chk("R4 first load", int'(out_data), 1000);
        phase = "R2"; put(0, 1, 1064); step(); // +1 at k=64
        chk("R2 k64 step", int'(out_data), 1001);
        // R3 code 7 aliases k=64
        phase = "R3"; filt_code = 7; put(0, 2, 1064); step();
        // R1 wrong unit and invalid channel dropped
        phase = "R1"; put(1, 0, 4000); step();
        put(0, 10, 4000); step();
        put(0, 15, 0); step();
        // R9 clear, R10 mask
        phase = "R9"; irq_clr = 2'b11; step();
        chk("R9 cleared", int'(irq_status), 0);
        phase = "R10"; irq_mask = 2'b01; put(0, 0, 50); step();
        chk("R10 masked done", int'(irq), 0);
        // R5 bypass
        phase = "R5"; filt_en = 0; put(0, 4, 777); step();
        chk("R5 bypass", int'(out_data), 777);
        // R7 strict high/low with equality
        phase = "R7"; irq_clr = 2'b11; step();
        mon_en = 1; mon_dir = 0; mon_thresh = 500; put(0, 0, 500); step();
        chk("R7 equal high", int'(irq_status[0]), 0);
        put(0, 0, 501); step();
        chk("R7 above", int'(irq_status[0]), 1);
        irq_clr = 2'b01; mon_dir = 1; put(0, 0, 500); step();
        chk("R7 equal low", int'(irq_status[0]), 0);
        put(0, 0, 499); step();
        chk("R7 below", int'(irq_status[0]), 1);
        // R9 set wins over clear
        irq_clr = 2'b11; put(0, 0, 10); step();
        chk("R9 set wins", int'(irq_status), 3);
        // R8 done flag
        phase = "R8"; irq_clr = 2'b11; step(); put(0, 9, 5); step();
        chk("R8 done", int'(irq_status[1]), 1);
        // R4 re-enable reloads
        phase = "R4"; filt_en = 1; filt_code = 0; put(0, 0, 3000); step();
        chk("R4 reload", int'(out_data), 3000);

        // Random mix
        phase = "random";
        for (int i = 0; i < 4000; i++) begin
            in_valid = ($urandom % 10) < 7;
            in_unit = ($urandom % 10) == 0;
            in_chan = CH_W'($urandom);
            in_data = DATA_W'($urandom);
            if (($urandom % 40) == 0) filt_en = ~filt_en;
            if (($urandom % 8) == 0) filt_code = 3'($urandom);
            if (($urandom % 16) == 0) begin
                mon_en = 1'($urandom); mon_dir = 1'($urandom);
                mon_thresh = DATA_W'($urandom);
            end
            irq_mask = 2'($urandom);
            irq_clr = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
            step();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule